// File: doc/BRIEF.md
# Management Interrupt Edge Recognizer

This block takes an active-low management interrupt request pin, which may change at any time relative to the clock, and turns each valid falling edge into exactly one service request. It synchronizes the pin and detects falling edges. An edge counts only when the synchronized pin has been high for enough clocks beforehand. A recognized request is held until an instruction-boundary strobe arrives outside a locked bus sequence. At that boundary the block emits a one-clock take pulse.

Taking a request masks further recognition until a resume pulse marks the end of service. While masked, one new edge can be held as pending. Any further edges are dropped. The pending request fires at the first boundary after the resume pulse, so the two services run back to back. The ordinary interrupt-enable flag never reaches this block. The block outranks the other non-maskable interrupt: it reports that interrupt as blocked while a management request is waiting or in service. That interrupt, in turn, never holds back a take.

Top module: `mirq_recognizer`

## Requirements
- R1: Asynchronous reset drives take_o, masked_o and nmi_blocked_o to 0, empties the waiting and pending slots, and counts the re-arm condition as satisfied, so the first falling edge after reset is accepted.
- R2: A high-to-low transition of mreq_ni yields exactly one take_o pulse, one clock wide, whether the pin stays low for one clock or for many.
- R3: A falling edge is accepted only if the synchronized pin was high for at least 4 consecutive clocks just before it. An earlier edge is discarded and leaves no pending request.
- R4: The pin goes through a two-flop synchronizer. If mreq_ni is low at clock edge k and a boundary is sampled at edge k+3, take_o is high after edge k+3. A boundary sampled at edge k+2 is too early for that request.
- R5: A take needs boundary_i high and locked_i low in the same sampled clock. Otherwise the request keeps waiting.
- R6: masked_o rises in the same cycle as take_o. No take occurs while masked. A resume_i pulse while masked clears masked_o on the next clock. resume_i while unmasked has no effect.
- R7: While masked, the first accepted edge is held as pending and later edges are dropped. After resume_i, the pending request is taken at the first qualifying boundary.
- R8: An edge accepted in the same cycle as a take becomes the pending request for the service that take starts.
- R9: nmi_blocked_o is high exactly when nmi_req_i is high and a request is either waiting or in service. nmi_req_i never delays or suppresses a take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mreq_ni | input | 1 | Management interrupt request pin, active low, asynchronous |
| boundary_i | input | 1 | Instruction-boundary strobe |
| locked_i | input | 1 | Locked bus sequence in progress |
| resume_i | input | 1 | End-of-service pulse |
| nmi_req_i | input | 1 | Lower-priority non-maskable request present |
| take_o | output | 1 | One-clock pulse: service request taken |
| masked_o | output | 1 | Service in progress, recognition masked |
| nmi_blocked_o | output | 1 | Lower-priority non-maskable request held off |

## Verification
Two pairs of events can meet in one cycle. The first pair is a newly accepted edge and a take of the waiting request. The second pair is a newly accepted edge and the resume pulse that ends service. The bench lines up the first pair on purpose: it spaces two edges so that the second edge's detection lands on the boundary clock that takes the first request. It then requires two takes in total. Random stimulus produces both pairs many times. A cycle-level reference model, written from the requirements, judges every cycle.

// File: rtl/mirq_pkg.sv
package mirq_pkg;
  localparam int unsigned SYNC_STAGES_DEF = 2;
  localparam int unsigned REARM_CLKS_DEF  = 4;

  typedef struct packed {
    logic svc;   // service in progress (mask)
    logic hold;  // request waiting for a boundary
    logic pend;  // request latched while masked
  } mirq_state_t;
endpackage

// File: rtl/mirq_sync.sv
module mirq_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[i] <= RST_VAL;
        else         stg_q[i] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[i] <= RST_VAL;
        else         stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/mirq_edge_arm.sv
module mirq_edge_arm #(
  parameter int unsigned REARM_CLKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,   // synchronized, active low
  output logic edge_o
);
  localparam int unsigned CNT_W = $clog2(REARM_CLKS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(REARM_CLKS);

  logic [CNT_W-1:0] hi_cnt_q;
  logic             prev_q;

  // counts consecutive high clocks, saturating; armed when full
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt_q <= CNT_MAX;
      prev_q   <= 1'b1;
    end else begin
      prev_q <= pin_i;
      if (!pin_i)                hi_cnt_q <= '0;
      else if (hi_cnt_q != CNT_MAX) hi_cnt_q <= hi_cnt_q + 1'b1;
    end
  end

  assign edge_o = prev_q && !pin_i && (hi_cnt_q == CNT_MAX);
endmodule

// File: rtl/mirq_svc_ctrl.sv
module mirq_svc_ctrl
  import mirq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  input  logic boundary_i,
  input  logic locked_i,
  input  logic resume_i,
  input  logic nmi_req_i,
  output logic take_o,
  output logic masked_o,
  output logic nmi_blocked_o
);
  mirq_state_t st_q, st_d;
  logic        take_q, take_d;

  always_comb begin
    st_d   = st_q;
    take_d = boundary_i && !locked_i && !st_q.svc && st_q.hold;
    if (take_d) begin
      st_d.svc  = 1'b1;
      st_d.hold = 1'b0;
      st_d.pend = edge_i;          // coincident edge waits behind this service
    end else if (st_q.svc) begin
      if (resume_i) begin
        st_d.svc  = 1'b0;
        st_d.hold = st_q.pend || edge_i;
        st_d.pend = 1'b0;
      end else if (edge_i) begin
        st_d.pend = 1'b1;          // single slot: repeats collapse
      end
    end else if (edge_i) begin
      st_d.hold = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= '0;
      take_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      take_q <= take_d;
    end
  end

  assign take_o        = take_q;
  assign masked_o      = st_q.svc;
  assign nmi_blocked_o = nmi_req_i && (st_q.svc || st_q.hold);
endmodule

// File: rtl/mirq_recognizer.sv
module mirq_recognizer
  import mirq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF,
  parameter int unsigned REARM_CLKS  = REARM_CLKS_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mreq_ni,
  input  logic boundary_i,
  input  logic locked_i,
  input  logic resume_i,
  input  logic nmi_req_i,
  output logic take_o,
  output logic masked_o,
  output logic nmi_blocked_o
);
  logic pin_s;
  logic edge_s;

  mirq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (mreq_ni),
    .q_o   (pin_s)
  );

  mirq_edge_arm #(.REARM_CLKS(REARM_CLKS)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pin_s),
    .edge_o(edge_s)
  );

  mirq_svc_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .edge_i       (edge_s),
    .boundary_i   (boundary_i),
    .locked_i     (locked_i),
    .resume_i     (resume_i),
    .nmi_req_i    (nmi_req_i),
    .take_o       (take_o),
    .masked_o     (masked_o),
    .nmi_blocked_o(nmi_blocked_o)
  );
endmodule

// File: rtl/mirq_recognizer_chk.sv
module mirq_recognizer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic boundary_i,
  input logic locked_i,
  input logic resume_i,
  input logic nmi_req_i,
  input logic take_o,
  input logic masked_o,
  input logic nmi_blocked_o
);
  p_take_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !take_o);

  p_take_qualified_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> $past(boundary_i && !locked_i));

  p_mask_with_take_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> masked_o);

  p_no_take_masked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> !$past(masked_o));

  p_mask_only_by_take_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(masked_o) |-> take_o);

  p_resume_unmasks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (masked_o && resume_i) |=> !masked_o);

  p_nmi_needs_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_blocked_o |-> nmi_req_i);

  p_nmi_held_masked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (masked_o && nmi_req_i) |-> nmi_blocked_o);
endmodule

bind mirq_recognizer mirq_recognizer_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .boundary_i   (boundary_i),
  .locked_i     (locked_i),
  .resume_i     (resume_i),
  .nmi_req_i    (nmi_req_i),
  .take_o       (take_o),
  .masked_o     (masked_o),
  .nmi_blocked_o(nmi_blocked_o)
);

// File: tb/mirq_recognizer_tb.sv
module mirq_recognizer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mreq_ni = 1'b1, boundary_i = 1'b0, locked_i = 1'b0;
  logic resume_i = 1'b0, nmi_req_i = 1'b0;
  logic take_o, masked_o, nmi_blocked_o;

  int checks = 0, errors = 0, ntake = 0;
  string cur_tag = "R1";
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mirq_recognizer dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .mreq_ni(mreq_ni), .boundary_i(boundary_i),
    .locked_i(locked_i), .resume_i(resume_i), .nmi_req_i(nmi_req_i),
    .take_o(take_o), .masked_o(masked_o), .nmi_blocked_o(nmi_blocked_o)
  );

  // reference model built from the requirements
  logic m_s1, m_s2, m_prev, m_take, m_svc, m_hold, m_pend;
  int   m_cnt;
  logic m_edge, m_take_d;
  assign m_edge   = m_prev && !m_s2 && (m_cnt >= 4);
  assign m_take_d = boundary_i && !locked_i && !m_svc && m_hold;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_s1 <= 1; m_s2 <= 1; m_prev <= 1; m_cnt <= 4;
      m_take <= 0; m_svc <= 0; m_hold <= 0; m_pend <= 0;
    end else begin
      m_s1 <= mreq_ni; m_s2 <= m_s1; m_prev <= m_s2;
      m_cnt <= !m_s2 ? 0 : (m_cnt < 4 ? m_cnt + 1 : 4);
      m_take <= m_take_d;
      if (m_take_d) begin
        m_svc <= 1; m_hold <= 0; m_pend <= m_edge;
      end else if (m_svc) begin
        if (resume_i) begin m_svc <= 0; m_hold <= m_pend | m_edge; m_pend <= 0; end
        else if (m_edge) m_pend <= 1;
      end else if (m_edge) m_hold <= 1;
    end
  end

  function automatic logic exp_nmi(logic req, logic svc, logic hold);
    return req && (svc || hold);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
    check(cur_tag, "take_o", take_o, m_take);
    check(cur_tag, "masked_o", masked_o, m_svc);
    check("R9", "nmi_blocked_o", nmi_blocked_o, exp_nmi(nmi_req_i, m_svc, m_hold));
    if (take_o) ntake++;
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic idle();
    boundary_i = 1; locked_i = 0; mreq_ni = 1;
    steps(8);
    if (masked_o) begin resume_i = 1; step(); resume_i = 0; end
    steps(6);
    ntake = 0;
  endtask

  task automatic do_resume();
    resume_i = 1; step(); resume_i = 0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #(CLK_PERIOD*2 + 2);
    // R1 reset state
    check("R1", "take_o in reset", take_o, 0);
    check("R1", "masked_o in reset", masked_o, 0);
    check("R1", "nmi_blocked_o in reset", nmi_blocked_o, 0);
    rst_ni = 1;
    steps(2);

    // R1 first edge after reset accepted; R2 long low gives one pulse
    cur_tag = "R2"; boundary_i = 1; nmi_req_i = 1; mreq_ni = 0;
    steps(30);
    check("R2", "takes for long low", ntake, 1);
    check("R1", "masked after first edge", masked_o, 1);
    check("R9", "nmi blocked while masked", nmi_blocked_o, 1);
    nmi_req_i = 0;
    idle();

    // R2 one-clock low
    mreq_ni = 0; step(); mreq_ni = 1; steps(6);
    check("R2", "takes for one-clock low", ntake, 1);
    idle();

    // R3 edge after 3 high clocks is discarded, even as pending
    cur_tag = "R3";
    mreq_ni = 0; step(); mreq_ni = 1; steps(3);
    mreq_ni = 0; step(); mreq_ni = 1; steps(10);
    do_resume(); steps(8);
    check("R3", "takes with short re-arm", ntake, 1);
    check("R6", "masked after resume", masked_o, 0);
    idle();

    // R3 edge after 4 high clocks accepted (becomes pending, R7)
    mreq_ni = 0; step(); mreq_ni = 1; steps(4);
    mreq_ni = 0; step(); mreq_ni = 1; steps(10);
    do_resume(); steps(6);
    check("R3", "takes with full re-arm", ntake, 2);
    idle();

    // R4 boundary two clocks after pin low is too early, three is enough
    cur_tag = "R4"; boundary_i = 0;
    mreq_ni = 0; step(); step(); boundary_i = 1; step(); boundary_i = 0; step();
    check("R4", "take on early boundary", ntake, 0);
    idle(); boundary_i = 0;
    mreq_ni = 0; step(); step(); step(); boundary_i = 1; step(); boundary_i = 0;
    check("R4", "take_o after boundary at k+3", take_o, 1);
    idle();

    // R5 locked sequence holds the request
    cur_tag = "R5"; locked_i = 1; nmi_req_i = 1;
    mreq_ni = 0; step(); mreq_ni = 1; steps(10);
    check("R5", "takes while locked", ntake, 0);
    check("R9", "nmi blocked while waiting", nmi_blocked_o, 1);
    locked_i = 0; steps(2);
    check("R5", "takes after unlock", ntake, 1);
    nmi_req_i = 0;
    idle();

    // R6 resume while unmasked ignored
    cur_tag = "R6";
    do_resume(); steps(4);
    check("R6", "masked after stray resume", masked_o, 0);
    check("R6", "takes after stray resume", ntake, 0);

    // R7 three edges while masked leave one pending
    cur_tag = "R7";
    mreq_ni = 0; step(); mreq_ni = 1; steps(6);
    for (int e = 0; e < 3; e++) begin
      mreq_ni = 0; step(); mreq_ni = 1; steps(6);
    end
    check("R7", "takes while masked", ntake, 1);
    do_resume(); steps(10);
    check("R7", "takes after resume", ntake, 2);
    check("R7", "masked for pending service", masked_o, 1);
    idle();

    // R8 edge detected on the take clock becomes pending
    cur_tag = "R8"; boundary_i = 0;
    mreq_ni = 0; step(); mreq_ni = 1; steps(5);
    mreq_ni = 0; step(); mreq_ni = 1; step();
    boundary_i = 1; step(); boundary_i = 0; steps(3);
    check("R8", "takes before resume", ntake, 1);
    do_resume(); boundary_i = 1; steps(4);
    check("R8", "takes total", ntake, 2);
    idle();

    // random mix judged by the model
    cur_tag = "R7";
    for (int c = 0; c < 6000; c++) begin
      if ($urandom % 6 == 0) mreq_ni = ~mreq_ni;
      boundary_i = ($urandom % 3 == 0);
      locked_i   = ($urandom % 5 == 0);
      nmi_req_i  = $urandom % 2;
      resume_i   = masked_o && ($urandom % 8 == 0);
      step();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule